// File: doc/BRIEF.md
# Two-Level Segment and Page Address Translator

This block turns a 20-bit logical address into a 20-bit physical address. The top four bits of the logical address select one of sixteen segment descriptors. Each descriptor holds a page-table base, a page-count limit and a two-bit access-rights code. The middle eight bits are the page within the segment. The sum of the base and that page, modulo 256, indexes a 256-entry page table. Each page-table entry holds a presence bit and a 12-bit block number. The low eight bits of the logical address are the word within the page, and they go straight into the low bits of the result. Both tables are internal register files, loaded through a write port. Any write to either table empties the translation buffer.

A four-entry associative buffer holds recent (segment, page) to block pairs and is searched first. A buffer hit returns its result one cycle after the request is accepted, and the access rights are still checked against the current descriptor. A buffer miss starts a walk. One cycle reads the descriptor and checks the limit and the rights. A second cycle reads the page entry. A successful walk stores its result in the buffer, and slots are replaced in strict rotation. Only one request is in flight at a time.

Top module: `seg_page_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0, and all table entries read as zero, so the first access to any segment returns a limit fault.
- R2: A successful response gives `rsp_paddr = {block[11:0], word[7:0]}`, where word is `req_addr[7:0]`, and `rsp_fault` is 0.
- R3: The page-table index is (descriptor base + `req_addr[15:8]`) modulo 256.
- R4: When the page field is not below the 9-bit limit, the response carries `rsp_fault` = 1 (limit fault).
- R5: Access-rights codes, with kind 0 = read, 1 = write, 2 = execute, 3 = never allowed: code 0 allows read and write, code 1 allows read only, code 2 allows execute only, and code 3 allows kinds 0 to 2 only when `req_sys` is 1. A denied access gets `rsp_fault` = 2. The rights are also checked on a buffer hit.
- R6: A page entry whose presence bit (bit 12) is clear gives `rsp_fault` = 3, and the failed translation is not stored in the buffer.
- R7: A limit fault takes priority over a protection fault.
- R8: Responses arrive a fixed number of cycles after the accepting edge: 1 for a buffer hit, 2 for a fault found at the descriptor, and 3 for a page-level result. `req_ready` is 0 while a walk is in progress.
- R9: After a successful walk, a repeat access to the same (segment, page) hits the buffer.
- R10: The buffer has four slots, filled and replaced in round-robin order.
- R11: Any table write invalidates every buffer entry.
- R12: On any fault, `rsp_paddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request; accepted when `req_ready` is 1 |
| req_addr | input | 20 | Logical address: segment [19:16], page [15:8], word [7:0] |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| req_sys | input | 1 | Privileged requester |
| req_ready | output | 1 | Idle and able to accept a request |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 1 | 0 selects a segment descriptor, 1 selects a page entry |
| tbl_idx | input | 8 | Entry index (the low 4 bits for a descriptor) |
| tbl_wdata | input | 19 | Descriptor: {rights[18:17], limit[16:8], base[7:0]}; page entry: {present[12], block[11:0]} in the low bits |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 20 | Physical address {block, word}, zero on a fault |
| rsp_fault | output | 2 | 0 none, 1 limit, 2 protection, 3 page not present |

## Verification
The hardest case to reach from the ports is the eviction order of the buffer. No output names a slot, so the bench infers each buffer hit or miss from the response latency of one cycle or three. It runs five successful walks in a fixed sequence, so that the fifth reuses the first slot. It then shows that the oldest translation now costs a full walk, while a younger one still hits. Rights checks that apply only on the hit path are reached by first caching a translation with a permitted kind, then repeating it with a denied kind.

// File: rtl/seg_page_xlate.sv
`timescale 1ns/1ps
module seg_page_xlate #(
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 8,
  parameter int WORD_W = 8,
  parameter int BLK_W  = 12,
  parameter int TLB_N  = 4,
  localparam int LA_W  = SEG_W + PAGE_W + WORD_W,
  localparam int PA_W  = BLK_W + WORD_W,
  localparam int LIM_W = PAGE_W + 1,
  localparam int SD_W  = 2 + LIM_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LA_W-1:0]   req_addr,
  input  logic [1:0]        req_kind,
  input  logic              req_sys,
  output logic              req_ready,
  input  logic              tbl_we,
  input  logic              tbl_sel,
  input  logic [PAGE_W-1:0] tbl_idx,
  input  logic [SD_W-1:0]   tbl_wdata,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [1:0]        rsp_fault
);
  localparam int NSEG  = 1 << SEG_W;
  localparam int NPT   = 1 << PAGE_W;
  localparam int PTR_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;

  typedef enum logic [1:0] {S_IDLE, S_SEG, S_PG} st_t;
  st_t st;

  logic [SD_W-1:0]   seg_tab [NSEG];
  logic [BLK_W:0]    pt_tab  [NPT];
  logic [TLB_N-1:0]  tlb_v;
  logic [SEG_W-1:0]  tlb_seg  [TLB_N];
  logic [PAGE_W-1:0] tlb_page [TLB_N];
  logic [BLK_W-1:0]  tlb_blk  [TLB_N];
  logic [PTR_W-1:0]  rr;

  logic [SEG_W-1:0]  q_seg;
  logic [PAGE_W-1:0] q_page, pt_idx;
  logic [WORD_W-1:0] q_word;
  logic [1:0]        q_kind;
  logic              q_sys;

  wire [SEG_W-1:0]  r_seg  = req_addr[LA_W-1 -: SEG_W];
  wire [PAGE_W-1:0] r_page = req_addr[WORD_W +: PAGE_W];
  wire [WORD_W-1:0] r_word = req_addr[WORD_W-1:0];

  assign req_ready = (st == S_IDLE);
  wire accept = req_valid && req_ready;

  function automatic logic rights_ok(input logic [1:0] code, input logic [1:0] kind, input logic sys);
    case (code)
      2'd0:    rights_ok = (kind == 2'd0) || (kind == 2'd1);
      2'd1:    rights_ok = (kind == 2'd0);
      2'd2:    rights_ok = (kind == 2'd2);
      default: rights_ok = sys && (kind != 2'd3);
    endcase
  endfunction

  logic [TLB_N-1:0] hit_vec;
  logic [BLK_W-1:0] hit_blk;
  for (genvar i = 0; i < TLB_N; i++) begin : g_cmp
    assign hit_vec[i] = tlb_v[i] && (tlb_seg[i] == r_seg) && (tlb_page[i] == r_page);
  end
  always_comb begin
    hit_blk = '0;
    for (int i = 0; i < TLB_N; i++)
      if (hit_vec[i]) hit_blk = hit_blk | tlb_blk[i];
  end

  wire [SD_W-1:0]   r_desc = seg_tab[r_seg];
  wire [SD_W-1:0]   w_desc = seg_tab[q_seg];
  wire [LIM_W-1:0]  w_lim  = w_desc[PAGE_W +: LIM_W];
  wire [PAGE_W-1:0] w_base = w_desc[PAGE_W-1:0];
  wire [BLK_W:0]    w_pte  = pt_tab[pt_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rsp_valid <= 1'b0;
      rsp_fault <= 2'd0;
      rsp_paddr <= '0;
      tlb_v     <= '0;
      rr        <= '0;
      q_seg <= '0; q_page <= '0; q_word <= '0; q_kind <= '0; q_sys <= 1'b0; pt_idx <= '0;
      for (int i = 0; i < NSEG; i++) seg_tab[i] <= '0;
      for (int i = 0; i < NPT; i++)  pt_tab[i]  <= '0;
      for (int i = 0; i < TLB_N; i++) begin
        tlb_seg[i] <= '0; tlb_page[i] <= '0; tlb_blk[i] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          q_seg <= r_seg; q_page <= r_page; q_word <= r_word;
          q_kind <= req_kind; q_sys <= req_sys;
          if (|hit_vec) begin
            rsp_valid <= 1'b1;
            if (rights_ok(r_desc[SD_W-1 -: 2], req_kind, req_sys)) begin
              rsp_fault <= 2'd0;
              rsp_paddr <= {hit_blk, r_word};
            end else begin
              rsp_fault <= 2'd2;
              rsp_paddr <= '0;
            end
          end else begin
            st <= S_SEG;
          end
        end
        S_SEG: begin
          if ({1'b0, q_page} >= w_lim) begin
            rsp_valid <= 1'b1; rsp_fault <= 2'd1; rsp_paddr <= '0; st <= S_IDLE;
          end else if (!rights_ok(w_desc[SD_W-1 -: 2], q_kind, q_sys)) begin
            rsp_valid <= 1'b1; rsp_fault <= 2'd2; rsp_paddr <= '0; st <= S_IDLE;
          end else begin
            pt_idx <= w_base + q_page;
            st     <= S_PG;
          end
        end
        S_PG: begin
          rsp_valid <= 1'b1;
          st        <= S_IDLE;
          if (!w_pte[BLK_W]) begin
            rsp_fault <= 2'd3; rsp_paddr <= '0;
          end else begin
            rsp_fault <= 2'd0;
            rsp_paddr <= {w_pte[BLK_W-1:0], q_word};
            tlb_v[rr]    <= 1'b1;
            tlb_seg[rr]  <= q_seg;
            tlb_page[rr] <= q_page;
            tlb_blk[rr]  <= w_pte[BLK_W-1:0];
            rr <= (rr == PTR_W'(TLB_N-1)) ? '0 : rr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (tbl_we) begin
        if (tbl_sel) pt_tab[tbl_idx] <= tbl_wdata[BLK_W:0];
        else         seg_tab[tbl_idx[SEG_W-1:0]] <= tbl_wdata;
        tlb_v <= '0;
      end
    end
  end

  // R11
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |=> (tlb_v == '0));

  // R10
  one_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tlb_v) <= $countones($past(tlb_v)) + 1);

  // R9
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R12
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

  // R2
  word_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd0) |-> (rsp_paddr[WORD_W-1:0] == q_word));

  // R8
  walk_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(|hit_vec)) |=> !req_ready);
endmodule

// File: tb/seg_page_xlate_tb.sv
`timescale 1ns/1ps
module seg_page_xlate_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_sys = 1'b0;
  logic        req_ready;
  logic        tbl_we = 1'b0;
  logic        tbl_sel = 1'b0;
  logic [7:0]  tbl_idx = '0;
  logic [18:0] tbl_wdata = '0;
  logic        rsp_valid;
  logic [19:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  seg_page_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_sys(req_sys), .req_ready(req_ready),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tbl_write(input bit sel, input logic [7:0] idx, input logic [18:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = sel; tbl_idx = idx; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  function automatic logic [18:0] desc(input logic [1:0] code, input logic [8:0] lim, input logic [7:0] base);
    return {code, lim, base};
  endfunction

  task automatic access(input logic [19:0] a, input logic [1:0] k, input bit s,
                        output logic [1:0] f, output logic [19:0] p, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = k; req_sys = s;
    lat = 0; f = '0; p = '0;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
      if (rsp_valid) begin
        f = rsp_fault; p = rsp_paddr;
        break;
      end
    end
  endtask

  // {addr20, kind2, sys1, fault2, paddr20, latency2}
  localparam logic [46:0] VEC [0:16] = '{
    {20'h1007E, 2'd0, 1'b0, 2'd0, 20'h0127E, 2'd3}, // R2 R8 walk success
    {20'h1007E, 2'd1, 1'b0, 2'd0, 20'h0127E, 2'd1}, // R9 hit
    {20'h10133, 2'd0, 1'b0, 2'd0, 20'h00033, 2'd3}, // R2
    {20'h10200, 2'd0, 1'b0, 2'd3, 20'h00000, 2'd3}, // R6 absent page
    {20'h10200, 2'd0, 1'b0, 2'd3, 20'h00000, 2'd3}, // R6 not cached
    {20'h10400, 2'd0, 1'b0, 2'd1, 20'h00000, 2'd2}, // R4 page equals limit
    {20'h215AB, 2'd0, 1'b0, 2'd0, 20'h019AB, 2'd3}, // R3 base wrap
    {20'h215AB, 2'd1, 1'b0, 2'd2, 20'h00000, 2'd1}, // R5 read-only on hit path
    {20'h22000, 2'd1, 1'b0, 2'd1, 20'h00000, 2'd2}, // R7 limit before rights
    {20'h3FF01, 2'd2, 1'b0, 2'd0, 20'h05301, 2'd3}, // R5 execute-only, limit 256
    {20'h3FF01, 2'd0, 1'b0, 2'd2, 20'h00000, 2'd1}, // R5 R12 read denied on hit
    {20'h4015A, 2'd0, 1'b0, 2'd2, 20'h00000, 2'd2}, // R5 system-only, unprivileged
    {20'h4015A, 2'd2, 1'b1, 2'd0, 20'h1005A, 2'd3}, // R5 R10 fifth fill reuses slot 0
    {20'h1007E, 2'd0, 1'b0, 2'd0, 20'h0127E, 2'd3}, // R10 oldest evicted
    {20'h3FF01, 2'd2, 1'b0, 2'd0, 20'h05301, 2'd1}, // R10 younger still cached
    {20'h10133, 2'd0, 1'b0, 2'd0, 20'h00033, 2'd3}, // R10 second slot evicted
    {20'h103FF, 2'd1, 1'b0, 2'd0, 20'hA61FF, 2'd3}  // R2 R10
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
    finish_run();
  end

  initial begin
    logic [1:0]  f;
    logic [19:0] p;
    int          lat;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1 no response in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;

    // R1 empty tables give a limit fault
    access(20'h10000, 2'd0, 1'b0, f, p, lat);
    chk(f == 2'd1 && lat == 2, "R1 empty table limit fault", {f, 8'(lat)}, {2'd1, 8'd2});

    tbl_write(1'b0, 8'h01, desc(2'd0, 9'd4,   8'h10));
    tbl_write(1'b0, 8'h02, desc(2'd1, 9'd32,  8'hF0));
    tbl_write(1'b0, 8'h03, desc(2'd2, 9'd256, 8'h40));
    tbl_write(1'b0, 8'h04, desc(2'd3, 9'd2,   8'h80));
    tbl_write(1'b1, 8'h10, {6'd0, 1'b1, 12'h012});
    tbl_write(1'b1, 8'h11, {6'd0, 1'b1, 12'h000});
    tbl_write(1'b1, 8'h12, {6'd0, 1'b0, 12'h555});
    tbl_write(1'b1, 8'h13, {6'd0, 1'b1, 12'hA61});
    tbl_write(1'b1, 8'h05, {6'd0, 1'b1, 12'h019});
    tbl_write(1'b1, 8'h3F, {6'd0, 1'b1, 12'h053});
    tbl_write(1'b1, 8'h81, {6'd0, 1'b1, 12'h100});

    for (int i = 0; i < 17; i++) begin
      logic [46:0] v;
      v = VEC[i];
      access(v[46:27], v[26:25], v[24], f, p, lat);
      chk(f == v[23:22] && p == v[21:2] && lat == int'(v[1:0]),
          $sformatf("vector %0d (R2-style fault/paddr/latency)", i),
          {f, p, 8'(lat)}, {v[23:22], v[21:2], 8'(v[1:0])});
    end

    // R11 table write empties the buffer; the new block is seen at walk latency
    access(20'h103FF, 2'd1, 1'b0, f, p, lat);
    chk(lat == 1, "R9 cached before flush", 64'(lat), 64'd1);
    tbl_write(1'b1, 8'h13, {6'd0, 1'b1, 12'h0AB});
    access(20'h103FF, 2'd1, 1'b0, f, p, lat);
    chk(f == 2'd0 && p == 20'h0ABFF && lat == 3, "R11 flush forces walk",
        {f, p, 8'(lat)}, {2'd0, 20'h0ABFF, 8'd3});

    // R8 ready drops during a walk
    @(negedge clk);
    req_valid = 1'b1; req_addr = 20'h10133; req_kind = 2'd0; req_sys = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R8 busy during walk", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk(req_ready == 1'b0 && rsp_valid == 1'b0, "R8 still walking",
        {req_ready, rsp_valid}, 2'b00);
    @(negedge clk);
    chk(rsp_valid && rsp_paddr == 20'h00033, "R8 response at third cycle",
        {rsp_valid, rsp_paddr}, {1'b1, 20'h00033});

    // R5 reserved kind is denied even to a privileged requester
    access(20'h40000, 2'd3, 1'b1, f, p, lat);
    chk(f == 2'd2 && p == 20'h0 && lat == 2, "R5 R12 reserved kind", {f, p, 8'(lat)}, {2'd2, 20'h0, 8'd2});

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule